// File: doc/BRIEF.md
# Timing Event Translation Gateway

This block turns decoded network timing messages into 16-bit event words for a legacy serial event bus. Each message brings a group identifier, an event number, a sequence identifier and a deadline. A message is kept only if its group matches the machine picked by a mode input and its event number fits in one byte. For each kept message the block packs the low byte of the event number and the low byte of the sequence identifier into one word. The word then waits in a four-entry queue.

Words leave the queue in arrival order, one at a time, over a valid/ready handshake to a serial transmitter. A word is never offered before its deadline. After each send the block stays busy for a fixed number of cycles, or for a longer burst time when the word carries the configured trigger code. Every word leaves as a 64-bit event identifier, with a fixed marker in the upper 48 bits.

When no real word has been issued for a long time, the block enters an idle state and sends a fill event at a fixed period. It leaves idle on the next real issue. Single-cycle status pulses report late sends, dropped messages, and entry into and exit from idle.

Top module: `tm_event_gateway`

## Requirements
- R1: A message is accepted only if msgGroup equals 0x12C when machineSel is 0, or 0x154 when machineSel is 1. Other messages are dropped.
- R2: A message whose event number is greater than 255 is dropped. Numbers 0 to 255 inclusive are accepted.
- R3: The issued identifier is 0xFFFFFFFF0000 in bits [63:16]. Bits [15:8] hold the low byte of the sequence identifier and bits [7:0] hold the low byte of the event number.
- R4: Accepted words are issued in arrival order, and each is issued only once nowTime is at or past its deadline. While txReady is low, the offered identifier and txValid stay unchanged.
- R5: After an issue (txValid and txReady high at a clock edge), no other issue happens for SEND_CYCLES cycles. If the issued word's event byte equals the trigger code, that time is BURST_CYCLES instead. A word that is already due goes out exactly that many cycles after the previous one.
- R6: lateStb is high for one cycle, in the cycle after an issue whose nowTime was strictly past its deadline, and is low otherwise.
- R7: The queue holds 4 words. A qualifying message that arrives while the queue is full is dropped, and ovflStb pulses for one cycle.
- R8: After IDLE_CYCLES cycles without a real issue, idleEnterStb pulses and a fill event is issued at once. A further fill event follows every FILL_CYCLES cycles. A fill word has 0x00 in bits [15:8] and the fill code in bits [7:0]. No fill is issued outside idle.
- R9: The first real issue in idle ends the idle state, and idleExitStb pulses for one cycle.
- R10: cfgFillCode and cfgTrigCode are captured while rst is high. Changes to them after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| machineSel | input | 1 | Machine select: 0 means group 0x12C, 1 means group 0x154 |
| cfgFillCode | input | 8 | Fill event code, captured in reset |
| cfgTrigCode | input | 8 | Event byte that starts the long busy time, captured in reset |
| nowTime | input | DL_W | Current time, compared with deadlines |
| msgValid | input | 1 | Incoming message strobe |
| msgGroup | input | 12 | Group identifier of the message |
| msgEvtNo | input | 12 | Event number of the message |
| msgSeqId | input | 8 | Low byte of the sequence identifier |
| msgDeadline | input | DL_W | Deadline of the message |
| txReady | input | 1 | Transmitter can accept an identifier |
| txValid | output | 1 | An identifier is offered |
| txEventId | output | 64 | Offered 64-bit event identifier |
| lateStb | output | 1 | Pulse: the previous issue was past its deadline |
| ovflStb | output | 1 | Pulse: a message was dropped because the queue was full |
| idleEnterStb | output | 1 | Pulse: idle state entered |
| idleExitStb | output | 1 | Pulse: idle state left |

## Verification
The idle state is the hardest condition to reach. It needs a long quiet stretch with no real issue. Every earlier test has to finish well inside that window, or a stray fill word would land among the real words being scored. So the bench sets the idle timeout larger than any gap in the earlier tests, and saves the idle test for last. In that test it stops all traffic and waits for the entry pulse. It then times the fill words against the fill period, and finally sends one real message to bring the block out of idle.

// File: rtl/gw_pkg.sv
package gw_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic pop;      // remove head word from the queue
    logic selFill;  // present the fill word instead of the head word
  } gwStrobe_t;

  localparam logic [47:0] ID_PREFIX = 48'hFFFF_FFFF_0000;
  localparam logic [11:0] GROUP_M0  = 12'h12C;
  localparam logic [11:0] GROUP_M1  = 12'h154;
endpackage

// File: rtl/gw_datapath.sv
module gw_datapath
  import gw_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DL_W  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            machineSel,
  input  logic [7:0]      cfgFillCode,
  input  logic [7:0]      cfgTrigCode,
  input  logic            msgValid,
  input  logic [11:0]     msgGroup,
  input  logic [11:0]     msgEvtNo,
  input  logic [7:0]      msgSeqId,
  input  logic [DL_W-1:0] msgDeadline,
  input  gwStrobe_t       strb,
  output logic            headValid,
  output logic [DL_W-1:0] headDeadline,
  output logic            headTrig,
  output logic [63:0]     txEventId,
  output logic            ovflStb
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [15:0]     memWord [DEPTH];
  logic [DL_W-1:0] memDl   [DEPTH];
  logic            memTrig [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [7:0] fillQ, trigQ;

  logic groupOk, accept, full, push;

  always_comb begin
    groupOk = (msgGroup == (machineSel ? GROUP_M1 : GROUP_M0));
    accept  = msgValid && groupOk && (msgEvtNo < 12'd256);
    full    = (count == CNT_W'(DEPTH));
    push    = accept && !full;
  end

  always_ff @(posedge clk) begin
    if (push) begin
      memWord[wrPtr] <= {msgSeqId, msgEvtNo[7:0]};
      memDl[wrPtr]   <= msgDeadline;
      memTrig[wrPtr] <= (msgEvtNo[7:0] == trigQ);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      ovflStb <= 1'b0;
      fillQ   <= cfgFillCode;
      trigQ   <= cfgTrigCode;
    end else begin
      ovflStb <= accept && full;
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (strb.pop) rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(strb.pop);
    end
  end

  always_comb begin
    headValid    = (count != '0);
    headDeadline = memDl[rdPtr];
    headTrig     = memTrig[rdPtr];
    txEventId    = {ID_PREFIX, strb.selFill ? {8'h00, fillQ} : memWord[rdPtr]};
  end

  // R7: occupancy never exceeds the queue depth
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  // R7: a drop pulse only follows a cycle with a full queue
  a_r7_ovfl_when_full: assert property (@(posedge clk) disable iff (rst)
    ovflStb |-> $past(count) == CNT_W'(DEPTH));
  // R4: control never pops an empty queue
  a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    strb.pop |-> count != '0);
endmodule

// File: rtl/gw_control.sv
module gw_control
  import gw_pkg::*;
#(
  parameter int SEND_CYCLES  = 20,
  parameter int BURST_CYCLES = 180,
  parameter int IDLE_CYCLES  = 900,
  parameter int FILL_CYCLES  = 900,
  parameter int DL_W         = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            headValid,
  input  logic [DL_W-1:0] headDeadline,
  input  logic            headTrig,
  input  logic [DL_W-1:0] nowTime,
  input  logic            txReady,
  output gwStrobe_t       strb,
  output logic            txValid,
  output logic            lateStb,
  output logic            idleEnterStb,
  output logic            idleExitStb
);
  localparam int BUSY_MAX = (BURST_CYCLES > SEND_CYCLES) ? BURST_CYCLES : SEND_CYCLES;
  localparam int TMR_MAX  = (IDLE_CYCLES > FILL_CYCLES) ? IDLE_CYCLES : FILL_CYCLES;
  localparam int BUSY_W   = $clog2(BUSY_MAX + 1);
  localparam int TMR_W    = $clog2(TMR_MAX + 1);

  logic [BUSY_W-1:0] busyCnt;
  logic [TMR_W-1:0]  tmr;
  logic              idle, fillPend;
  logic [DL_W-1:0]   diff;
  logic              busy, due, realGo, fillGo, fire;

  always_comb begin
    diff         = nowTime - headDeadline;
    busy         = (busyCnt != '0);
    due          = headValid && !diff[DL_W-1];
    realGo       = !busy && due;
    fillGo       = !busy && !due && fillPend;
    txValid      = realGo || fillGo;
    fire         = txValid && txReady;
    strb.pop     = realGo && txReady;
    strb.selFill = !realGo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyCnt      <= '0;
      tmr          <= '0;
      idle         <= 1'b0;
      fillPend     <= 1'b0;
      lateStb      <= 1'b0;
      idleEnterStb <= 1'b0;
      idleExitStb  <= 1'b0;
    end else begin
      lateStb      <= strb.pop && (diff != '0);
      idleEnterStb <= 1'b0;
      idleExitStb  <= 1'b0;

      if (fire)
        busyCnt <= (realGo && headTrig) ? BUSY_W'(BURST_CYCLES - 1) : BUSY_W'(SEND_CYCLES - 1);
      else if (busy)
        busyCnt <= busyCnt - 1'b1;

      if (fillGo && txReady) fillPend <= 1'b0;

      if (strb.pop) begin
        tmr <= '0;
        if (idle) begin
          idle        <= 1'b0;
          idleExitStb <= 1'b1;
          fillPend    <= 1'b0;
        end
      end else if (!idle) begin
        if (tmr == TMR_W'(IDLE_CYCLES - 1)) begin
          idle         <= 1'b1;
          idleEnterStb <= 1'b1;
          fillPend     <= 1'b1;
          tmr          <= '0;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end else begin
        if (tmr == TMR_W'(FILL_CYCLES - 1)) begin
          fillPend <= 1'b1;
          tmr      <= '0;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end

  // R5: an issue is followed by at least one quiet cycle
  a_r5_issue_gap: assert property (@(posedge clk) disable iff (rst)
    fire |=> !txValid);
  // R6: late pulse only right after an issue
  a_r6_late_after_issue: assert property (@(posedge clk) disable iff (rst)
    lateStb |-> $past(fire));
  // R8, R9: entry and exit never pulse together
  a_r8_idle_pulse_excl: assert property (@(posedge clk) disable iff (rst)
    !(idleEnterStb && idleExitStb));
  // R9: exit only follows a real issue
  a_r9_exit_after_real: assert property (@(posedge clk) disable iff (rst)
    idleExitStb |-> $past(strb.pop));
  // R4: offer is held while the transmitter stalls
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (txValid && !txReady && !strb.selFill) |=> txValid);
endmodule

// File: rtl/tm_event_gateway.sv
module tm_event_gateway
  import gw_pkg::*;
#(
  parameter int DEPTH        = 4,
  parameter int DL_W         = 32,
  parameter int SEND_CYCLES  = 20,
  parameter int BURST_CYCLES = 180,
  parameter int IDLE_CYCLES  = 900,
  parameter int FILL_CYCLES  = 900
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            machineSel,
  input  logic [7:0]      cfgFillCode,
  input  logic [7:0]      cfgTrigCode,
  input  logic [DL_W-1:0] nowTime,
  input  logic            msgValid,
  input  logic [11:0]     msgGroup,
  input  logic [11:0]     msgEvtNo,
  input  logic [7:0]      msgSeqId,
  input  logic [DL_W-1:0] msgDeadline,
  input  logic            txReady,
  output logic            txValid,
  output logic [63:0]     txEventId,
  output logic            lateStb,
  output logic            ovflStb,
  output logic            idleEnterStb,
  output logic            idleExitStb
);
  gwStrobe_t       strb;
  logic            headValid, headTrig;
  logic [DL_W-1:0] headDeadline;

  gw_datapath #(.DEPTH(DEPTH), .DL_W(DL_W)) u_dp (
    .clk(clk), .rst(rst), .machineSel(machineSel),
    .cfgFillCode(cfgFillCode), .cfgTrigCode(cfgTrigCode),
    .msgValid(msgValid), .msgGroup(msgGroup), .msgEvtNo(msgEvtNo),
    .msgSeqId(msgSeqId), .msgDeadline(msgDeadline), .strb(strb),
    .headValid(headValid), .headDeadline(headDeadline), .headTrig(headTrig),
    .txEventId(txEventId), .ovflStb(ovflStb)
  );

  gw_control #(
    .SEND_CYCLES(SEND_CYCLES), .BURST_CYCLES(BURST_CYCLES),
    .IDLE_CYCLES(IDLE_CYCLES), .FILL_CYCLES(FILL_CYCLES), .DL_W(DL_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .headValid(headValid), .headDeadline(headDeadline),
    .headTrig(headTrig), .nowTime(nowTime), .txReady(txReady), .strb(strb),
    .txValid(txValid), .lateStb(lateStb),
    .idleEnterStb(idleEnterStb), .idleExitStb(idleExitStb)
  );
endmodule

// File: tb/tm_event_gateway_test.sv
module tm_event_gateway_test;
  localparam int SEND  = 20;
  localparam int BURST = 180;
  localparam int IDLE  = 1500;
  localparam int FILL  = 600;
  localparam logic [7:0] FILL_CODE = 8'hE1;
  localparam logic [7:0] TRIG_CODE = 8'h37;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic machineSel = 1'b0;
  logic [7:0] cfgFillCode = FILL_CODE;
  logic [7:0] cfgTrigCode = TRIG_CODE;
  logic [31:0] nowTime = '0;
  logic msgValid = 1'b0;
  logic [11:0] msgGroup = '0, msgEvtNo = '0;
  logic [7:0] msgSeqId = '0;
  logic [31:0] msgDeadline = '0;
  logic txReady = 1'b1;
  logic txValid, lateStb, ovflStb, idleEnterStb, idleExitStb;
  logic [63:0] txEventId;

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) nowTime <= nowTime + 1;

  tm_event_gateway #(.SEND_CYCLES(SEND), .BURST_CYCLES(BURST),
                     .IDLE_CYCLES(IDLE), .FILL_CYCLES(FILL)) uut (
    .clk(clk), .rst(rst), .machineSel(machineSel), .cfgFillCode(cfgFillCode),
    .cfgTrigCode(cfgTrigCode), .nowTime(nowTime), .msgValid(msgValid),
    .msgGroup(msgGroup), .msgEvtNo(msgEvtNo), .msgSeqId(msgSeqId),
    .msgDeadline(msgDeadline), .txReady(txReady), .txValid(txValid),
    .txEventId(txEventId), .lateStb(lateStb), .ovflStb(ovflStb),
    .idleEnterStb(idleEnterStb), .idleExitStb(idleExitStb)
  );

  typedef struct { logic [63:0] id; logic [31:0] dl; logic trig; } expItem_t;
  expItem_t expQ[$];

  int nChecks = 0, nFail = 0;
  int ovflCnt = 0, enterCnt = 0, exitCnt = 0, fillCnt = 0, realCnt = 0;
  int lastFire = -1; logic lastTrig = 1'b0;
  int lastFill = -1;
  int realFire[$];
  logic lateCheckPend = 1'b0, lateExp = 1'b0;
  logic done = 1'b0;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: sample at negedge, away from the active edge
  always @(negedge clk) if (!rst) begin
    int now;
    now = int'(nowTime);
    if (lateCheckPend) begin
      chk(lateStb == lateExp, "R6 late pulse", 64'(lateStb), 64'(lateExp));
      lateCheckPend = 1'b0;
    end else if (lateStb) begin
      chk(1'b0, "R6 stray late pulse", 64'(lateStb), 64'd0);
    end
    if (ovflStb) ovflCnt++;
    if (idleEnterStb) enterCnt++;
    if (idleExitStb) exitCnt++;
    if (txValid && txReady) begin
      if (lastFire >= 0)
        chk(now - lastFire >= (lastTrig ? BURST : SEND), "R5 issue spacing",
            64'(now - lastFire), 64'(lastTrig ? BURST : SEND));
      lastFire = now;
      if (txEventId == {48'hFFFFFFFF0000, 8'h00, FILL_CODE}) begin
        fillCnt++;
        chk(enterCnt > exitCnt, "R8 fill only in idle", 64'(enterCnt), 64'(exitCnt + 1));
        if (lastFill >= 0)
          chk(now - lastFill == FILL, "R8 fill period", 64'(now - lastFill), 64'(FILL));
        lastFill = now;
        lastTrig = 1'b0;
        lateExp = 1'b0; lateCheckPend = 1'b1;
      end else if (expQ.size() == 0) begin
        chk(1'b0, "R1/R2/R3 unexpected word", txEventId, 64'd0);
        lastTrig = 1'b0;
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        realCnt++;
        realFire.push_back(now);
        chk(txEventId == e.id, "R3/R4 issued word", txEventId, e.id);
        chk(now >= int'(e.dl), "R4 not before deadline", 64'(now), 64'(e.dl));
        lateExp = (now > int'(e.dl)); lateCheckPend = 1'b1;
        lastTrig = e.trig;
        lastFill = -1;
      end
    end
  end

  // Driver: one message per call
  task automatic sendMsg(input logic [11:0] grp, input logic [11:0] evt, input logic [7:0] seq,
                         input int dlOfs, input logic expAccept, input logic trig);
    @(negedge clk);
    msgValid = 1'b1; msgGroup = grp; msgEvtNo = evt; msgSeqId = seq;
    msgDeadline = nowTime + 32'(dlOfs);
    if (expAccept) begin
      expItem_t e;
      e.id = {48'hFFFFFFFF0000, seq, evt[7:0]};
      e.dl = msgDeadline;
      e.trig = trig;
      expQ.push_back(e);
    end
    @(negedge clk);
    msgValid = 1'b0;
  endtask

  task automatic drain(input int extra);
    int guard = 0;
    while (expQ.size() != 0 && guard < 5000) begin @(negedge clk); guard++; end
    repeat (extra) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin : main
    int n0, e0, x0, o0, r0, f0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: configuration changes after reset must be ignored
    cfgFillCode = 8'h00; cfgTrigCode = 8'h00;
    chk(!txValid && !lateStb && !ovflStb && !idleEnterStb && !idleExitStb,
        "reset state", {59'd0, txValid, lateStb, ovflStb, idleEnterStb, idleExitStb}, 64'd0);

    // R1 R3 R4: accepted message issued at its deadline
    sendMsg(12'h12C, 12'h005, 8'h3A, 40, 1'b1, 1'b0);
    drain(30);
    // R1: wrong group for machine 0 is dropped
    r0 = realCnt;
    sendMsg(12'h154, 12'h006, 8'h11, 5, 1'b0, 1'b0);
    // R2: event number 256 is dropped, 255 accepted
    sendMsg(12'h12C, 12'h100, 8'h12, 5, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    chk(realCnt == r0, "R1/R2 dropped messages issue nothing", 64'(realCnt), 64'(r0));
    sendMsg(12'h12C, 12'h0FF, 8'h13, 5, 1'b1, 1'b0);
    drain(30);
    // R1: machine 1 group
    machineSel = 1'b1;
    sendMsg(12'h154, 12'h021, 8'hC4, 5, 1'b1, 1'b0);
    drain(30);

    // R4: stall holds offer
    sendMsg(12'h154, 12'h022, 8'hC5, 3, 1'b0, 1'b0);
    txReady = 1'b0;
    begin expItem_t e; e.id = {48'hFFFFFFFF0000, 8'hC5, 8'h22}; e.dl = nowTime - 32'd0; e.trig = 1'b0; end
    repeat (10) @(negedge clk);
    chk(txValid == 1'b1, "R4 offer held on stall", 64'(txValid), 64'd1);
    chk(txEventId == {48'hFFFFFFFF0000, 8'hC5, 8'h22}, "R4 word held on stall",
        txEventId, {48'hFFFFFFFF0000, 8'hC5, 8'h22});
    begin expItem_t e; e.id = {48'hFFFFFFFF0000, 8'hC5, 8'h22}; e.dl = nowTime - 32'd20; e.trig = 1'b0; expQ.push_back(e); end
    @(negedge clk);
    txReady = 1'b1;
    drain(30);

    // R5 R6 R10: two words due together; code 0x00 must not act as trigger
    machineSel = 1'b0;
    n0 = realFire.size();
    sendMsg(12'h12C, 12'h000, 8'h44, 10, 1'b1, 1'b0);
    expQ[expQ.size()-1].dl = msgDeadline;
    sendMsg(12'h12C, 12'h009, 8'h45, 9, 1'b1, 1'b0);
    drain(30);
    if (realFire.size() >= n0 + 2)
      chk(realFire[n0+1] - realFire[n0] == SEND, "R5 back-to-back spacing",
          64'(realFire[n0+1] - realFire[n0]), 64'(SEND));
    else chk(1'b0, "R5 two words issued", 64'(realFire.size() - n0), 64'd2);

    // R5 R10: trigger code stretches busy time
    n0 = realFire.size();
    sendMsg(12'h12C, 12'(TRIG_CODE), 8'h01, 5, 1'b1, 1'b1);
    sendMsg(12'h12C, 12'h010, 8'h02, 4, 1'b1, 1'b0);
    drain(30);
    if (realFire.size() >= n0 + 2)
      chk(realFire[n0+1] - realFire[n0] == BURST, "R5 burst busy time",
          64'(realFire[n0+1] - realFire[n0]), 64'(BURST));
    else chk(1'b0, "R5 burst words issued", 64'(realFire.size() - n0), 64'd2);

    // R7: fifth message into a full queue is dropped
    o0 = ovflCnt;
    for (int i = 0; i < 4; i++) sendMsg(12'h12C, 12'(8'h50 + i), 8'h60, 80, 1'b1, 1'b0);
    sendMsg(12'h12C, 12'h059, 8'h61, 80, 1'b0, 1'b0);
    @(negedge clk);
    chk(ovflCnt == o0 + 1, "R7 overflow pulse", 64'(ovflCnt), 64'(o0 + 1));
    drain(40);
    chk(expQ.size() == 0, "R7 queued words issued", 64'(expQ.size()), 64'd0);

    // R8 R9 R10: idle entry, fill period, exit
    chk(fillCnt == 0 && enterCnt == 0, "R8 no fill before idle", 64'(fillCnt), 64'd0);
    e0 = enterCnt; x0 = exitCnt; f0 = fillCnt;
    begin
      int g = 0;
      while (enterCnt == e0 && g < 3000) begin @(negedge clk); g++; end
    end
    chk(enterCnt == e0 + 1, "R8 idle entry pulse", 64'(enterCnt), 64'(e0 + 1));
    repeat (FILL * 2 + 20) @(negedge clk);
    chk(fillCnt == f0 + 3, "R8 fill events issued", 64'(fillCnt), 64'(f0 + 3));
    sendMsg(12'h12C, 12'h070, 8'h71, 3, 1'b1, 1'b0);
    drain(10);
    chk(exitCnt == x0 + 1, "R9 idle exit pulse", 64'(exitCnt), 64'(x0 + 1));
    chk(expQ.size() == 0, "R4 all expected words issued", 64'(expQ.size()), 64'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule